// File: doc/BRIEF.md
# Protected Page-Write Command Controller

This block decides which bus writes may reach a byte-wide nonvolatile array of 8192 bytes with 13 address bits. Plain data writes are never taken at face value. The bus master must first issue a fixed three-write unlock sequence. Only after that sequence does the block take up to one 32-byte page of data into a page buffer. It then hands the page to the array as a single commit request, with a page base address, a per-byte mask and the byte data. A busy flag covers the internal write time that follows.

Two independent gates stand in the write path. The external write-control input must be high for any bus write to count at all. A block-lock register holds one bit for each of the eight 1K regions, and bytes aimed at a locked region are dropped from the commit mask. A second unlock variant, with a different final command byte, loads that lock register from the data of the next accepted write.

Top module: `prot_page_writer`

## Requirements
- R1: After reset, `busy` and `commit_valid` are low and every region is unlocked (lock register all zeros).
- R2: A page load is armed only by three accepted writes in a row: 0xAA at 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555. Data writes with no such sequence before them never lead to a commit.
- R3: An accepted write that does not match the next expected step of the sequence returns the detector to its start, so the whole sequence must be given again.
- R4: A bus write made while `wr_ctl` is low is ignored completely: it advances no sequence, loads no byte and changes no lock bit.
- R5: The first data byte after arming fixes the page as address bits 12..5. `commit_base` equals that page address with bits 4..0 zero. Each byte of the page is placed at byte lane addr[4:0] of `commit_data` (bits 8*k+7..8*k), and its bit k in `commit_mask` is set.
- R6: An accepted write outside the current page ends loading. That write is dropped, and `commit_valid` is high in the cycle right after the edge that took it.
- R7: When no accepted write arrives, `commit_valid` rises TMO clock edges after the edge that took the last page byte (TMO = 16 by default).
- R8: `busy` goes high together with `commit_valid` and stays high for exactly WCYC cycles (40 by default). Every bus write during that time is ignored.
- R9: The sequence 0xAA at 0x1555, 0x55 at 0x0AAA, 0xC0 at 0x1555 makes the data of the next accepted write (any address) the new lock register. Bit i locks region i, which is addr[12:10] == i.
- R10: Bytes written to a locked region are left out of `commit_mask`. A commit is still issued, and bytes in unlocked regions are committed normally.
- R11: `commit_valid` is a single-cycle pulse, and it is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | 13 | Write address |
| bus_data | input | 8 | Write data |
| wr_ctl | input | 1 | External write enable; low blocks all writes |
| commit_valid | output | 1 | One-cycle page commit request |
| commit_base | output | 13 | Page base address of the commit |
| commit_mask | output | 32 | Bytes of the page to program |
| commit_data | output | 256 | Page data, byte k at bits 8k+7..8k |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Writes are taken on a rising edge, and each result has a fixed due time after that edge. A page closed by an out-of-page write shows `commit_valid` one cycle later. A page closed by the idle timeout shows it TMO edges after the last byte. `busy` holds for WCYC cycles from that pulse, and a lock-register load affects the page written right after it. A behavioural reference model in the bench steps on the same edges, and its outputs are compared with the design's outputs at every falling edge. Directed checks then measure the commit latency against the recorded cycle of the closing write, and the busy length against WCYC.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   typedef enum logic [2:0] {
      PW_IDLE  = 3'd0,
      PW_ARMED = 3'd1,
      PW_LOAD  = 3'd2,
      PW_PROT  = 3'd3,
      PW_BUSY  = 3'd4
   } pw_state_e;

endpackage

// File: rtl/pwc_unlock.sv
module pwc_unlock #(
   parameter int          ADDR_W   = 13,
   parameter int          DATA_W   = 8,
   parameter logic [12:0] SEQ_A1   = 13'h1555,
   parameter logic [7:0]  SEQ_D1   = 8'hAA,
   parameter logic [12:0] SEQ_A2   = 13'h0AAA,
   parameter logic [7:0]  SEQ_D2   = 8'h55,
   parameter logic [7:0]  CMD_PAGE = 8'hA0,
   parameter logic [7:0]  CMD_PROT = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              go_page,
   output logic              go_prot
);

   if (ADDR_W != 13 || DATA_W != 8) begin : g_bad_width
      $error("pwc_unlock: sequence constants assume 13-bit address, 8-bit data");
   end

   logic [1:0] stage_q, stage_d;
   logic       hit1, hit2, hit3a;

   assign hit1  = (addr == SEQ_A1) && (data == SEQ_D1);
   assign hit2  = (addr == SEQ_A2) && (data == SEQ_D2);
   assign hit3a = (addr == SEQ_A1);

   always_comb begin
      stage_d = stage_q;
      go_page = 1'b0;
      go_prot = 1'b0;
      if (wr) begin
         unique case (stage_q)
            2'd0:    stage_d = hit1 ? 2'd1 : 2'd0;
            2'd1:    stage_d = hit2 ? 2'd2 : 2'd0;
            default: begin
               stage_d = 2'd0;
               go_page = hit3a && (data == CMD_PAGE);
               go_prot = hit3a && (data == CMD_PROT);
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stage_q <= 2'd0;
      else        stage_q <= stage_d;
   end

   // R3: after any command decode the detector starts over
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (go_page || go_prot) |=> (stage_q == 2'd0));

   // R2: a command only follows two matched steps
   a_r2_cmd_needs_seq: assert property (@(posedge clk) disable iff (!rst_n)
      go_page |-> (stage_q == 2'd2) && wr);

endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
   parameter int PAGE_BYTES = 32,
   parameter int DATA_W     = 8,
   localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         wr,
   input  logic [OFS_W-1:0]             ofs,
   input  logic [DATA_W-1:0]            din,
   input  logic                         keep,
   output logic [PAGE_BYTES-1:0]        mask,
   output logic [PAGE_BYTES*DATA_W-1:0] dout
);

   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("pwc_page_buf: PAGE_BYTES must be a power of two");
   end

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
      logic             sel;
      logic [DATA_W-1:0] byte_q;
      logic             bit_q;

      assign sel = wr && (ofs == OFS_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bit_q  <= 1'b0;
            byte_q <= '0;
         end else begin
            if (clr)      bit_q <= sel && keep;
            else if (sel) bit_q <= keep;
            if (sel)      byte_q <= din;
         end
      end

      assign mask[i] = bit_q;
      assign dout[i*DATA_W +: DATA_W] = byte_q;
   end

   // R5: a single accepted write touches at most one mask lane unless clearing
   a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> ($countones(mask ^ $past(mask)) <= 1));

   // R5: without a write or clear the buffer holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !clr) |=> $stable(mask) && $stable(dout));

endmodule

// File: rtl/pwc_timers.sv
module pwc_timers #(
   parameter int TMO  = 16,
   parameter int WCYC = 40,
   localparam int TW  = $clog2(TMO + 1),
   localparam int BW  = $clog2(WCYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_restart,
   input  logic idle_run,
   output logic idle_expired,
   input  logic busy_load,
   input  logic busy_run,
   output logic busy_done
);

   if (TMO < 2)  begin : g_bad_tmo  $error("pwc_timers: TMO must be at least 2");  end
   if (WCYC < 1) begin : g_bad_wcyc $error("pwc_timers: WCYC must be at least 1"); end

   logic [TW-1:0] icnt_q;
   logic [BW-1:0] bcnt_q;

   assign idle_expired = (icnt_q == TW'(TMO - 1));
   assign busy_done    = (bcnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         icnt_q <= '0;
      end else if (idle_restart) begin
         icnt_q <= '0;
      end else if (idle_run && !idle_expired) begin
         icnt_q <= icnt_q + TW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcnt_q <= '0;
      end else if (busy_load) begin
         bcnt_q <= BW'(WCYC - 1);
      end else if (busy_run && !busy_done) begin
         bcnt_q <= bcnt_q - BW'(1);
      end
   end

   // R8: a new write cycle is only started after the previous one ran out
   a_r8_load_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy_load |-> busy_done);

   // R7: the idle count never passes its limit
   a_r7_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      icnt_q <= TW'(TMO - 1));

endmodule

// File: rtl/prot_page_writer.sv
module prot_page_writer
   import pwc_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int REGIONS    = 8,
   parameter int TMO        = 16,
   parameter int WCYC       = 40
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_data,
   input  logic                         wr_ctl,
   output logic                         commit_valid,
   output logic [ADDR_W-1:0]            commit_base,
   output logic [PAGE_BYTES-1:0]        commit_mask,
   output logic [PAGE_BYTES*DATA_W-1:0] commit_data,
   output logic                         busy
);

   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFS_W;
   localparam int REG_W = $clog2(REGIONS);

   if ((1 << REG_W) != REGIONS || REG_W > PG_W) begin : g_bad_regions
      $error("prot_page_writer: REGIONS must be a power of two no larger than the page count");
   end
   if (DATA_W < REGIONS) begin : g_bad_lockw
      $error("prot_page_writer: lock register loads from one data byte");
   end

   pw_state_e          state_q, state_d;
   logic [PG_W-1:0]    page_q;
   logic [REGIONS-1:0] prot_q;
   logic               cv_q;

   logic               acc, in_win, keep, commit;
   logic               go_page, go_prot;
   logic               idle_expired, busy_done;
   logic [REG_W-1:0]   region;

   assign acc    = bus_we && wr_ctl;
   assign in_win = (bus_addr[ADDR_W-1:OFS_W] == page_q);
   assign region = bus_addr[ADDR_W-1 -: REG_W];
   assign keep   = !prot_q[region];
   assign commit = (state_q == PW_LOAD) &&
                   ((acc && !in_win) || (!acc && idle_expired));

   pwc_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (acc && (state_q == PW_IDLE)),
      .addr    (bus_addr),
      .data    (bus_data),
      .go_page (go_page),
      .go_prot (go_prot)
   );

   pwc_timers #(.TMO(TMO), .WCYC(WCYC)) u_timers (
      .clk          (clk),
      .rst_n        (rst_n),
      .idle_restart (acc && ((state_q == PW_ARMED) || ((state_q == PW_LOAD) && in_win))),
      .idle_run     (state_q == PW_LOAD),
      .idle_expired (idle_expired),
      .busy_load    (commit),
      .busy_run     (state_q == PW_BUSY),
      .busy_done    (busy_done)
   );

   pwc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc && (state_q == PW_ARMED)),
      .wr    (acc && ((state_q == PW_ARMED) || ((state_q == PW_LOAD) && in_win))),
      .ofs   (bus_addr[OFS_W-1:0]),
      .din   (bus_data),
      .keep  (keep),
      .mask  (commit_mask),
      .dout  (commit_data)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PW_IDLE: begin
            if (go_page)      state_d = PW_ARMED;
            else if (go_prot) state_d = PW_PROT;
         end
         PW_ARMED: if (acc)       state_d = PW_LOAD;
         PW_LOAD:  if (commit)    state_d = PW_BUSY;
         PW_PROT:  if (acc)       state_d = PW_IDLE;
         PW_BUSY:  if (busy_done) state_d = PW_IDLE;
         default:                 state_d = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PW_IDLE;
         page_q  <= '0;
         prot_q  <= '0;
         cv_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         cv_q    <= commit;
         if (acc && (state_q == PW_ARMED)) page_q <= bus_addr[ADDR_W-1:OFS_W];
         if (acc && (state_q == PW_PROT))  prot_q <= bus_data[REGIONS-1:0];
      end
   end

   assign commit_valid = cv_q;
   assign commit_base  = {page_q, {OFS_W{1'b0}}};
   assign busy         = (state_q == PW_BUSY);

   // R11: commit is a single-cycle pulse
   a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> !commit_valid);

   // R11: commit only appears with busy
   a_r11_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> busy);

   // R4: with write control low, waiting states do not move
   a_r4_ctl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctl && (state_q inside {PW_IDLE, PW_ARMED, PW_PROT})) |=> $stable(state_q));

   // R9: the lock register only changes right after the lock command
   a_r9_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_q) |-> ($past(state_q) == PW_PROT));

   // R10: a page inside a locked region commits no byte
   a_r10_locked_page: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && prot_q[commit_base[ADDR_W-1 -: REG_W]]) |-> (commit_mask == '0));

   // R8: page data stays put while the write cycle runs
   a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(commit_mask) && $stable(commit_base));

endmodule

// File: tb/sim_prot_page_writer.sv
module sim_prot_page_writer;

   localparam int TMO  = 16;
   localparam int WCYC = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [12:0]   bus_addr = '0;
   logic [7:0]    bus_data = '0;
   logic          wr_ctl = 1'b1;
   logic          commit_valid;
   logic [12:0]   commit_base;
   logic [31:0]   commit_mask;
   logic [255:0]  commit_data;
   logic          busy;

   always #10 clk = ~clk;

   prot_page_writer #(.TMO(TMO), .WCYC(WCYC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_data(bus_data), .wr_ctl(wr_ctl), .commit_valid(commit_valid),
      .commit_base(commit_base), .commit_mask(commit_mask),
      .commit_data(commit_data), .busy(busy));

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // ---------------- reference model ----------------
   int         m_st = 0;      // 0 idle,1 armed,2 load,3 lock,4 busy
   int         m_seq = 0;
   int         m_tmo = 0;
   int         m_bc = 0;
   int         m_page = 0;
   bit         m_cv = 0;
   logic [7:0] m_prot = 0;
   logic [7:0] m_dat [32];
   bit         m_msk [32];

   function automatic void m_put(int a, logic [7:0] d);
      m_dat[a % 32] = d;
      m_msk[a % 32] = !m_prot[a / 1024];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_seq = 0; m_tmo = 0; m_bc = 0; m_page = 0; m_cv = 0; m_prot = 0;
         foreach (m_msk[i]) m_msk[i] = 0;
      end else begin
         automatic bit acc = bus_we && wr_ctl;
         automatic int a = int'(bus_addr);
         automatic bit do_commit = 0;
         m_cv = 0;
         case (m_st)
            0: if (acc) begin
               if (m_seq == 0 && a == 'h1555 && bus_data == 8'hAA) m_seq = 1;
               else if (m_seq == 1 && a == 'h0AAA && bus_data == 8'h55) m_seq = 2;
               else if (m_seq == 2 && a == 'h1555 && bus_data == 8'hA0) begin m_seq = 0; m_st = 1; end
               else if (m_seq == 2 && a == 'h1555 && bus_data == 8'hC0) begin m_seq = 0; m_st = 3; end
               else m_seq = 0;
            end
            1: if (acc) begin
               foreach (m_msk[i]) m_msk[i] = 0;
               m_page = a / 32; m_put(a, bus_data); m_tmo = 0; m_st = 2;
            end
            2: begin
               if (acc) begin
                  if (a / 32 == m_page) begin m_put(a, bus_data); m_tmo = 0; end
                  else do_commit = 1;
               end else if (m_tmo == TMO - 1) do_commit = 1;
               else m_tmo++;
            end
            3: if (acc) begin m_prot = bus_data; m_st = 0; end
            default: if (m_bc == 0) m_st = 0; else m_bc--;
         endcase
         if (do_commit) begin m_st = 4; m_bc = WCYC - 1; m_cv = 1; end
      end
   end

   // ---------------- monitor ----------------
   int         n_commit = 0;
   int         cv_cyc = 0;
   logic [31:0] last_mask;
   logic [255:0] last_data;
   logic [12:0] last_base;
   int         busy_run_len = 0;
   int         busy_last_len = 0;
   bit         mon_on = 0;

   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         check(busy === (m_st == 4), "R8 busy", 64'(busy), 64'(m_st == 4));
         check(commit_valid === m_cv, "R7 commit_valid", 64'(commit_valid), 64'(m_cv));
         if (m_cv) begin
            automatic logic [31:0] em = '0;
            foreach (m_msk[i]) em[i] = m_msk[i];
            check(commit_base === 13'(m_page * 32), "R5 commit_base", 64'(commit_base), 64'(m_page * 32));
            check(commit_mask === em, "R10 commit_mask", 64'(commit_mask), 64'(em));
            for (int i = 0; i < 32; i++)
               if (em[i]) check(commit_data[i*8 +: 8] === m_dat[i], "R5 commit_data",
                                64'(commit_data[i*8 +: 8]), 64'(m_dat[i]));
         end
      end
      if (commit_valid === 1'b1) begin
         n_commit++; cv_cyc = cyc;
         last_mask = commit_mask; last_data = commit_data; last_base = commit_base;
      end
      if (busy === 1'b1) busy_run_len++;
      else begin
         if (busy_run_len != 0) busy_last_len = busy_run_len;
         busy_run_len = 0;
      end
   end

   // ---------------- stimulus ----------------
   int last_wr_cyc = 0;

   task automatic bw(input logic [12:0] a, input logic [7:0] d, input bit ctl = 1);
      bus_we = 1; bus_addr = a; bus_data = d; wr_ctl = ctl;
      @(negedge clk);
      bus_we = 0; wr_ctl = 1;
      last_wr_cyc = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock(input logic [7:0] cmd, input bit ctl = 1);
      bw(13'h1555, 8'hAA, ctl);
      bw(13'h0AAA, 8'h55, ctl);
      bw(13'h1555, cmd, ctl);
   endtask

   localparam int SETTLE = TMO + WCYC + 6;

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      join_none

      idle(4);
      @(negedge clk);
      // R1: reset state
      check(busy === 1'b0, "R1 busy after reset", 64'(busy), 0);
      check(commit_valid === 1'b0, "R1 commit_valid after reset", 64'(commit_valid), 0);
      rst_n = 1; mon_on = 1;
      idle(2);

      begin : t_r2_plain
         automatic int c0 = n_commit;
         bw(13'h0040, 8'h12); bw(13'h0041, 8'h34); bw(13'h0042, 8'h56);
         idle(SETTLE);
         check(n_commit == c0, "R2 no commit without unlock", 64'(n_commit - c0), 0);
      end

      begin : t_r5_r7_page
         automatic int c0 = n_commit;
         automatic int wc;
         unlock(8'hA0);
         bw(13'h0040, 8'h11); bw(13'h0041, 8'h22); bw(13'h0045, 8'h33); bw(13'h005F, 8'h44);
         wc = last_wr_cyc;
         idle(TMO + 4);
         check(n_commit == c0 + 1, "R7 one commit after timeout", 64'(n_commit - c0), 1);
         check(cv_cyc - wc == TMO, "R7 timeout latency", 64'(cv_cyc - wc), 64'(TMO));
         check(last_base === 13'h0040, "R5 base", 64'(last_base), 64'h40);
         check(last_mask === 32'h8000_0023, "R5 mask", 64'(last_mask), 64'h8000_0023);
         check(last_data[5*8 +: 8] === 8'h33, "R5 lane 5 data", 64'(last_data[5*8 +: 8]), 64'h33);
         idle(WCYC);
         check(busy_last_len == WCYC, "R8 busy length", 64'(busy_last_len), 64'(WCYC));
         check(commit_valid === 1'b0, "R11 pulse ended", 64'(commit_valid), 0);
      end

      begin : t_r3_mismatch
         automatic int c0 = n_commit;
         bw(13'h1555, 8'hAA); bw(13'h0AAA, 8'h56); bw(13'h1555, 8'hA0);
         bw(13'h0080, 8'h77);
         idle(SETTLE);
         check(n_commit == c0, "R3 broken sequence gives no commit", 64'(n_commit - c0), 0);
      end

      begin : t_r4_ctl
         automatic int c0 = n_commit;
         unlock(8'hA0, 0);
         bw(13'h00A0, 8'h99);
         idle(SETTLE);
         check(n_commit == c0, "R4 unlock with ctl low ignored", 64'(n_commit - c0), 0);
         unlock(8'hA0);
         bw(13'h00A1, 8'h5A, 0);
         idle(SETTLE);
         check(n_commit == c0, "R4 data with ctl low ignored", 64'(n_commit - c0), 0);
         bw(13'h00A2, 8'hC3);
         idle(SETTLE);
         check(n_commit == c0 + 1, "R4 later byte commits", 64'(n_commit - c0), 1);
         check(last_mask === 32'h0000_0004, "R4 only ctl-high byte", 64'(last_mask), 64'h4);
      end

      begin : t_r6_r8_window
         automatic int c0 = n_commit;
         unlock(8'hA0);
         bw(13'h0100, 8'hE1); bw(13'h0101, 8'hE2); bw(13'h0140, 8'hE3);
         @(negedge clk);
         check(n_commit == c0 + 1, "R6 out-of-page write commits", 64'(n_commit - c0), 1);
         check(cv_cyc == last_wr_cyc, "R6 commit next cycle", 64'(cv_cyc - last_wr_cyc), 0);
         check(last_mask === 32'h0000_0003, "R6 closing byte dropped", 64'(last_mask), 64'h3);
         unlock(8'hA0);
         bw(13'h0200, 8'h42);
         idle(SETTLE);
         check(n_commit == c0 + 1, "R8 writes during busy ignored", 64'(n_commit - c0), 1);
      end

      begin : t_r9_r10_lock
         automatic int c0 = n_commit;
         unlock(8'hC0);
         bw(13'h0123, 8'h04);
         unlock(8'hA0);
         bw(13'h0800, 8'hAB); bw(13'h0801, 8'hCD);
         idle(SETTLE);
         check(n_commit == c0 + 1, "R10 locked page still commits", 64'(n_commit - c0), 1);
         check(last_mask === 32'h0, "R10 locked bytes dropped", 64'(last_mask), 0);
         unlock(8'hA0);
         bw(13'h0400, 8'hAB); bw(13'h0403, 8'hCD);
         idle(SETTLE);
         check(last_mask === 32'h9, "R9 region 1 still writable", 64'(last_mask), 64'h9);
         check(last_base === 13'h0400, "R9 base", 64'(last_base), 64'h400);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule